// File: doc/BRIEF.md
# I2C SCL Period Generator

This block produces the serial clock waveform for an I2C controller and tells the neighbouring byte engine when it may move SDA and when it should sample SDA. All timing is counted in cycles of the peripheral clock. Software loads a low-width and a high-width count. Every bit then runs one low phase, followed by one high phase. Inside the low phase, the point where SDA may change is taken from the upper bits of the low-width count. The data hold time therefore tracks the low period with no setting of its own.

The byte engine sends one of three commands: start, bit or stop. A one-cycle `ready` indication accepts each command. `ready` is raised while the block owns a parked bus and also on the final cycle of a high phase. Because of this, back-to-back commands chain without an extra low cycle. The start and stop sequences use the high-width count as their setup and hold times. The high-phase counter only advances once the SCL line has been seen high for a number of consecutive cycles set by the speed mode, so a target that stretches the clock lengthens the high phase. While the engine asserts its wait input, every counter and every strobe is frozen.

Top module: `sclgen`

## Requirements
- R1: While reset is asserted, and right after it is released, `scl_out` is 1 (released), `owned` is 0, `ready` is 1 and all four strobes are 0.
- R2: For a bit command (code 2) accepted from a parked bus or on the last high cycle, SCL is low for exactly max(`low_width`,1) cycles.
- R3: `sda_chg` pulses exactly once in each low phase, `low_width[9:2]` cycles after SCL falls. The first low cycle counts as index 0.
- R4: The high phase counts only after `scl_in` has been seen high for N consecutive cycles, with N=1 when `fast_mode`=1 and N=2 when it is 0. Without stretching, SCL is high for N+max(`high_width`,1) cycles, and `sda_smp` pulses at high index N.
- R5: If `scl_in` is held low for S cycles after `scl_out` rises, the high phase and the `sda_smp` index both grow by exactly S.
- R6: A start command (code 1) with `start_en`=1 releases SCL. It pulses `sda_fall` after max(`high_width`,1) qualified high cycles, then holds SCL high for exactly max(`high_width`,1) more cycles before it drives SCL low.
- R7: A start command while `start_en`=0 has no effect: SCL stays released and the bus stays unowned.
- R8: A stop command (code 3) runs one low phase timed as in R2/R3, then releases SCL. `sda_rise` pulses on high cycle N+S+max(`high_width`,1), counted inclusively. On the next cycle `owned` is 0.
- R9: While `wait_hold`=1, no counter advances, no strobe fires and no command is accepted. A strobe that was due fires once, after the wait ends.
- R10: A width setting of 0 behaves exactly like a setting of 1.
- R11: Bit and stop commands given while the bus is unowned have no effect.
- R12: At most one strobe is active in any cycle. `sda_chg` only occurs with SCL low, and `sda_smp` only occurs with SCL high on both `scl_out` and `scl_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| low_width | input | 10 | SCL low count in clock cycles |
| high_width | input | 10 | SCL high count in clock cycles |
| fast_mode | input | 1 | 1 selects fast mode (shorter high-level qualification) |
| start_en | input | 1 | Allows start conditions to be generated |
| cmd_valid | input | 1 | Command request from the byte engine |
| cmd_code | input | 2 | 1 start, 2 bit, 3 stop |
| wait_hold | input | 1 | Freezes all timing while 1 |
| scl_in | input | 1 | SCL level observed on the bus |
| ready | output | 1 | Command is taken on this cycle if `cmd_valid` is 1 |
| owned | output | 1 | Bus is held by this controller |
| scl_out | output | 1 | SCL drive: 0 pulls low, 1 releases |
| sda_chg | output | 1 | Strobe: SDA may change now |
| sda_smp | output | 1 | Strobe: sample SDA now |
| sda_fall | output | 1 | Strobe: drive SDA low for the start condition |
| sda_rise | output | 1 | Strobe: release SDA for the stop condition |

## Verification
The wait input and the SDA-change strobe can collide. The bench provokes this by raising `wait_hold` on exactly the low-phase cycle whose index equals `low_width[9:2]`, so freeze and strobe fall in the same cycle. The scoreboard then expects the strobe W cycles late, exactly once, and the low phase W cycles longer. A second collision is a target stretch on the rising edge together with the high-level qualification window. In that case the sample strobe index must grow by exactly the stretch length.

// File: rtl/sclg_pkg.sv
package sclg_pkg;

   typedef enum logic [1:0] {
      CMD_NONE  = 2'd0,
      CMD_START = 2'd1,
      CMD_BIT   = 2'd2,
      CMD_STOP  = 2'd3
   } sclg_cmd_e;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_PARK,
      ST_LOW,
      ST_HIGH,
      ST_SSET,
      ST_SHOLD,
      ST_PLOW,
      ST_PSET
   } sclg_state_e;

endpackage

// File: rtl/sclg_hi_filter.sv
// Counts consecutive cycles of SCL seen high; qualifies after N cycles,
// where N depends on the speed mode.
module sclg_hi_filter #(
   parameter int FILT_STD  = 2,
   parameter int FILT_FAST = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_in,
   input  logic fast,
   output logic qual
);
   localparam int NMAX = (FILT_STD > FILT_FAST) ? FILT_STD : FILT_FAST;
   localparam int CW   = $clog2(NMAX + 1);

   logic [CW-1:0] need;
   logic [CW-1:0] run;

   assign need = fast ? CW'(FILT_FAST) : CW'(FILT_STD);
   assign qual = (run >= need);

   generate
      if (NMAX == 1) begin : g_flop
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) run <= '0;
            else        run <= CW'(scl_in);
         end
      end else begin : g_count
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 run <= '0;
            else if (!scl_in)           run <= '0;
            else if (run != CW'(NMAX))  run <= run + 1'b1;
         end
      end
   endgenerate
endmodule

// File: rtl/sclg_phase_cnt.sv
// Phase counter: advances on tick, wraps on the last cycle of the phase.
// A width of zero is treated as one.
module sclg_phase_cnt #(
   parameter int WB = 10
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   input  logic [WB-1:0] width,
   output logic [WB-1:0] cnt,
   output logic          last
);
   logic [WB-1:0] eff;

   assign eff  = (width == '0) ? WB'(1) : width;
   assign last = tick && (cnt == eff - WB'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cnt <= '0;
      else if (last) cnt <= '0;
      else if (tick) cnt <= cnt + WB'(1);
   end
endmodule

// File: rtl/sclgen.sv
module sclgen
   import sclg_pkg::*;
#(
   parameter int WB        = 10,
   parameter int FILT_STD  = 2,
   parameter int FILT_FAST = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [WB-1:0] low_width,
   input  logic [WB-1:0] high_width,
   input  logic          fast_mode,
   input  logic          start_en,
   input  logic          cmd_valid,
   input  logic [1:0]    cmd_code,
   input  logic          wait_hold,
   input  logic          scl_in,
   output logic          ready,
   output logic          owned,
   output logic          scl_out,
   output logic          sda_chg,
   output logic          sda_smp,
   output logic          sda_fall,
   output logic          sda_rise
);
   localparam int HB = WB - 2;

   generate
      if (WB < 4) begin : g_bad_wb
         $error("sclgen: WB must be at least 4");
      end
      if (FILT_STD < 1 || FILT_FAST < 1) begin : g_bad_filt
         $error("sclgen: filter lengths must be at least 1");
      end
   endgenerate

   sclg_state_e   st, st_n;
   logic          qual, tick, last, take, low_ph, high_ph;
   logic [WB-1:0] cnt, ph_width, hold_pt;
   sclg_state_e   dispatch;

   sclg_hi_filter #(.FILT_STD(FILT_STD), .FILT_FAST(FILT_FAST)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .scl_in (scl_in),
      .fast   (fast_mode),
      .qual   (qual)
   );

   assign low_ph   = (st == ST_LOW) || (st == ST_PLOW);
   assign high_ph  = (st == ST_HIGH) || (st == ST_SSET) ||
                     (st == ST_SHOLD) || (st == ST_PSET);
   assign ph_width = low_ph ? low_width : high_width;
   assign hold_pt  = {2'b00, low_width[WB-1:2]};
   assign tick     = !wait_hold && (low_ph || (high_ph && qual));

   sclg_phase_cnt #(.WB(WB)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .width (ph_width),
      .cnt   (cnt),
      .last  (last)
   );

   assign ready = !wait_hold &&
                  ((st == ST_IDLE) || (st == ST_PARK) ||
                   (last && ((st == ST_HIGH) || (st == ST_SHOLD))));
   assign take  = cmd_valid && ready;

   always_comb begin
      dispatch = ST_PARK;
      if (take) begin
         unique case (sclg_cmd_e'(cmd_code))
            CMD_START: dispatch = start_en ? ST_SSET : ST_PARK;
            CMD_BIT:   dispatch = ST_LOW;
            CMD_STOP:  dispatch = ST_PLOW;
            default:   dispatch = ST_PARK;
         endcase
      end
   end

   always_comb begin
      st_n = st;
      unique case (st)
         ST_IDLE:  if (take && start_en && sclg_cmd_e'(cmd_code) == CMD_START)
                      st_n = ST_SSET;
         ST_PARK:  st_n = dispatch;
         ST_LOW:   if (last) st_n = ST_HIGH;
         ST_HIGH:  if (last) st_n = dispatch;
         ST_SSET:  if (last) st_n = ST_SHOLD;
         ST_SHOLD: if (last) st_n = dispatch;
         ST_PLOW:  if (last) st_n = ST_PSET;
         ST_PSET:  if (last) st_n = ST_IDLE;
         default:  st_n = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st <= ST_IDLE;
      else        st <= st_n;
   end

   assign scl_out  = !(low_ph || (st == ST_PARK));
   assign owned    = (st != ST_IDLE);
   assign sda_chg  = tick && low_ph && (cnt == hold_pt);
   assign sda_smp  = tick && (st == ST_HIGH) && (cnt == '0);
   assign sda_fall = last && (st == ST_SSET);
   assign sda_rise = last && (st == ST_PSET);

   logic [HB-1:0] unused_hb;
   assign unused_hb = '0;
endmodule

// File: rtl/sclgen_chk.sv
module sclgen_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       start_en,
   input logic       cmd_valid,
   input logic [1:0] cmd_code,
   input logic       wait_hold,
   input logic       scl_in,
   input logic       ready,
   input logic       owned,
   input logic       scl_out,
   input logic       sda_chg,
   input logic       sda_smp,
   input logic       sda_fall,
   input logic       sda_rise
);
   // R3
   chg_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_chg |-> !scl_out);

   // R12
   smp_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_smp |-> (scl_out && scl_in));

   // R12
   one_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sda_chg, sda_smp, sda_fall, sda_rise}));

   // R9
   wait_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wait_hold |=> ($stable(scl_out) && $stable(owned)));

   // R6
   start_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_fall |=> scl_out);

   // R8
   stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sda_rise |=> (scl_out && !owned));

   // R7
   start_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_code == 2'd1 && !start_en && !owned && ready) |=> !owned);
endmodule

bind sclgen sclgen_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start_en  (start_en),
   .cmd_valid (cmd_valid),
   .cmd_code  (cmd_code),
   .wait_hold (wait_hold),
   .scl_in    (scl_in),
   .ready     (ready),
   .owned     (owned),
   .scl_out   (scl_out),
   .sda_chg   (sda_chg),
   .sda_smp   (sda_smp),
   .sda_fall  (sda_fall),
   .sda_rise  (sda_rise)
);

// File: tb/sim_sclgen.sv
`timescale 1ns/1ps
module sim_sclgen;
   localparam int K_CHG = 0, K_LOW = 1, K_SMP = 2, K_HIGH = 3, K_GAP = 4, K_RISE = 5;

   typedef struct {
      int    kind;
      int    val;
      string req;
   } exp_t;

   logic       clk = 0;
   logic       rst_n = 0;
   logic [9:0] low_width = 10'd8, high_width = 10'd8;
   logic       fast_mode = 0, start_en = 1, cmd_valid = 0, wait_hold = 0;
   logic [1:0] cmd_code = 0;
   logic       scl_in, ready, owned, scl_out, sda_chg, sda_smp, sda_fall, sda_rise;
   logic       stretch_on = 0;

   int   checks = 0, failures = 0;
   bit   done = 0;
   exp_t exp_q[$];
   int   stretch_n = 0;
   int   s_left = 0;
   bit   prev_s = 1;
   int   wait_k = 0, wait_w = 0, w_left = 0, lc = 0;
   bit   wait_arm = 0, prev_w = 1;
   int   lo_cnt = 0, hi_cnt = 0, gap_cnt = 0, multi_strobe = 0;
   bit   prev_m = 1, seg_fall = 0, seg_valid = 0;

   always #4 clk = ~clk;

   assign scl_in = scl_out & ~stretch_on;

   sclgen u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .low_width  (low_width),
      .high_width (high_width),
      .fast_mode  (fast_mode),
      .start_en   (start_en),
      .cmd_valid  (cmd_valid),
      .cmd_code   (cmd_code),
      .wait_hold  (wait_hold),
      .scl_in     (scl_in),
      .ready      (ready),
      .owned      (owned),
      .scl_out    (scl_out),
      .sda_chg    (sda_chg),
      .sda_smp    (sda_smp),
      .sda_fall   (sda_fall),
      .sda_rise   (sda_rise)
   );

   function automatic string kname(int k);
      case (k)
         K_CHG:  return "chg";
         K_LOW:  return "low";
         K_SMP:  return "smp";
         K_HIGH: return "high";
         K_GAP:  return "start_gap";
         default: return "rise";
      endcase
   endfunction

   function automatic void check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endfunction

   function automatic void push(int k, int v, string r);
      exp_t e;
      e.kind = k; e.val = v; e.req = r;
      exp_q.push_back(e);
   endfunction

   function automatic void got(int k, int v);
      exp_t e;
      if (exp_q.size() == 0) begin
         check(0, "R12", {"unexpected ", kname(k)}, v, -1);
      end else begin
         e = exp_q.pop_front();
         check(e.kind == k, e.req, {"kind ", kname(e.kind)}, k, e.kind);
         check(e.val == v, e.req, kname(k), v, e.val);
      end
   endfunction

   // stretch model: holds scl_in low for stretch_n cycles after each rise
   always @(negedge clk) begin
      if (s_left > 0) begin
         s_left--;
         if (s_left == 0) stretch_on = 0;
      end
      if (scl_out && !prev_s && stretch_n > 0) begin
         stretch_on = 1;
         s_left = stretch_n;
      end
      prev_s = scl_out;
   end

   // wait injection at low-phase index wait_k for wait_w cycles
   always @(negedge clk) begin
      if (w_left > 0) begin
         w_left--;
         if (w_left == 0) wait_hold = 0;
      end
      if (!scl_out) begin
         if (prev_w) lc = 0;
         if (wait_arm && lc == wait_k) begin
            wait_hold = 1;
            w_left = wait_w;
            wait_arm = 0;
         end
         lc++;
      end
      prev_w = scl_out;
   end

   // monitor
   always begin
      @(negedge clk);
      #1;
      if (rst_n) begin
         if ($countones({sda_chg, sda_smp, sda_fall, sda_rise}) > 1) multi_strobe++;
         if (!scl_out) begin
            if (prev_m) begin
               if (seg_fall) got(K_GAP, gap_cnt);
               else if (seg_valid) got(K_HIGH, hi_cnt);
               lo_cnt = 0;
            end
            if (sda_chg) got(K_CHG, lo_cnt);
            lo_cnt++;
         end else begin
            if (!prev_m) begin
               got(K_LOW, lo_cnt);
               hi_cnt = 0;
               seg_fall = 0;
               seg_valid = 1;
            end
            if (sda_smp) got(K_SMP, hi_cnt);
            if (sda_rise) got(K_RISE, hi_cnt + 1);
            if (seg_fall) gap_cnt++;
            if (sda_fall) begin
               seg_fall = 1;
               gap_cnt = 0;
            end
            hi_cnt++;
         end
         prev_m = scl_out;
      end
   end

   task automatic issue(input logic [1:0] c);
      cmd_code = c;
      cmd_valid = 1;
      #2;
      while (!ready) begin
         @(negedge clk);
         #2;
      end
      @(negedge clk);
      cmd_valid = 0;
      cmd_code = 0;
   endtask

   task automatic xfer(input int lw, input int hw, input bit fm, input int nbits,
                       input int s, input int w, input int k, input bit rs);
      int efl, efh, hold, n;
      string rl, rh, rc;
      @(negedge clk);
      low_width = 10'(lw);
      high_width = 10'(hw);
      fast_mode = fm;
      stretch_n = s;
      wait_k = k;
      wait_w = w;
      wait_arm = (w > 0);
      efl = (lw == 0) ? 1 : lw;
      efh = (hw == 0) ? 1 : hw;
      hold = lw >> 2;
      n = fm ? 1 : 2;
      rl = (lw == 0) ? "R10" : "R2";
      rh = (hw == 0) ? "R10" : ((s > 0) ? "R5" : "R4");
      rc = (w > 0) ? "R9" : "R3";
      push(K_GAP, efh, "R6");
      if (rs) begin
         push(K_CHG, hold, "R3");
         push(K_LOW, efl, rl);
         push(K_SMP, s + n, rh);
         push(K_GAP, efh, "R6");
      end
      for (int b = 0; b < nbits; b++) begin
         push(K_CHG, hold + ((b == 0 && !rs) ? w : 0), (b == 0) ? rc : "R3");
         push(K_LOW, efl + ((b == 0 && !rs) ? w : 0), (b == 0 && w > 0) ? "R9" : rl);
         push(K_SMP, s + n, rh);
         push(K_HIGH, s + n + efh, rh);
      end
      push(K_CHG, hold, "R8");
      push(K_LOW, efl, "R8");
      push(K_RISE, s + n + efh, "R8");
      issue(2'd1);
      if (rs) begin
         issue(2'd2);
         issue(2'd1);
      end
      for (int b = 0; b < nbits; b++) issue(2'd2);
      issue(2'd3);
      while (owned) @(negedge clk);
      repeat (4) @(negedge clk);
      #2;
      check(exp_q.size() == 0, "R8", "pending events", exp_q.size(), 0);
      check(!owned && scl_out && ready, "R8", "idle after stop", {owned, scl_out, ready}, 3'b011);
      exp_q.delete();
      stretch_n = 0;
   endtask

   task automatic idle_probe(input string req, input logic [1:0] c, input bit en);
      int bad = 0;
      start_en = en;
      issue(c);
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         #2;
         if (!scl_out || owned || sda_fall || sda_chg) bad++;
      end
      check(bad == 0, req, "command ignored", bad, 0);
      start_en = 1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      #2;
      check(scl_out && !owned && ready, "R1", "in reset", {scl_out, owned, ready}, 3'b101);
      check({sda_chg, sda_smp, sda_fall, sda_rise} == 4'b0, "R1", "strobes in reset",
            {sda_chg, sda_smp, sda_fall, sda_rise}, 0);
      rst_n = 1;
      @(negedge clk);
      #2;
      check(scl_out && !owned && ready, "R1", "after reset", {scl_out, owned, ready}, 3'b101);
      @(negedge clk);
      idle_probe("R11", 2'd2, 1);
      idle_probe("R11", 2'd3, 1);
      idle_probe("R7", 2'd1, 0);
      check(exp_q.size() == 0, "R7", "no events", exp_q.size(), 0);
      xfer(20, 17, 0, 2, 0, 0, 0, 0);        // standard mode
      xfer(13, 9, 1, 3, 0, 0, 0, 0);         // fast mode
      xfer(0, 0, 1, 2, 0, 0, 0, 0);          // R10 zero widths, fast
      xfer(0, 0, 0, 1, 0, 0, 0, 0);          // R10 zero widths, standard
      xfer(20, 17, 0, 2, 5, 0, 0, 0);        // R5 stretch, standard
      xfer(16, 11, 1, 1, 3, 0, 0, 0);        // R5 stretch, fast
      xfer(24, 10, 1, 2, 0, 4, 6, 0);        // R9 wait collides with change point
      xfer(24, 10, 0, 1, 0, 3, 1, 0);        // R9 wait before change point
      xfer(16, 12, 1, 1, 0, 0, 0, 1);        // R6 repeated start
      xfer(1023, 1023, 1, 1, 0, 0, 0, 0);    // full-range widths
      check(multi_strobe == 0, "R12", "cycles with several strobes", multi_strobe, 0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog actual=timeout expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule